// File: doc/BRIEF.md
# Flash program/erase sequencer

This block runs write and erase operations on a small embedded non-volatile array. The array is modelled here as a register file of halfwords, split into main pages followed by information pages. Software drives one command at a time on a strobe interface. A command is a halfword program, an erase of one page, or an erase of the whole main area. The block checks the command, starts it, and times it. The operation length counts pulses of `tick`, a strobe derived from a fixed-frequency reference clock. It never counts system clock cycles, so the timing stays the same whatever the system clock setting.

While an operation runs, `busy` is high. On completion the array is updated, `busy` drops, and a sticky end-of-operation flag is set. That flag drives an interrupt when it is enabled. The interrupt requests a wake from a wait-for-interrupt state only while the interface clock enable is set; otherwise the flag simply stays pending.

Some commands are refused and only raise an error flag: a command issued while busy, a blocked or protected target, and a program to a halfword that is not blank. The information pages survive a mass erase and can only be written with an explicit enable.

Top module: `flash_seq`

## Requirements
- R1: A program command writes `cmd_wdata` into the single halfword at `cmd_addr` and changes no other halfword. `rd_data` returns the halfword at `rd_addr` combinationally, or 16'hFFFF for an address beyond the array.
- R2: A page erase sets to 16'hFFFF every halfword of the page that holds `cmd_addr` (page = address / PAGE_HW) and leaves the other pages as they were.
- R3: A mass erase sets every main-area halfword (addresses below MAIN_PAGES*PAGE_HW) to 16'hFFFF and leaves every information halfword unchanged. It ignores `cmd_addr` and `info_wen`.
- R4: An accepted operation completes at the clock edge where `tick` is sampled high, while busy, for the Nth time. N is PROG_TICKS for a program, PAGE_TICKS for a page erase and MASS_TICKS for a mass erase (3, 6 and 10 by default). Cycles without `tick` do not count.
- R5: `busy` rises in the cycle after a command is accepted and falls at the same edge that sets the end-of-operation flag.
- R6: `flags` bit 0 is the end-of-operation flag. It is sticky and is cleared by a 1 in `flag_clr[0]`. This works for every flag: bit n of `flag_clr` clears bit n of `flags`. A flag being set in the same cycle wins over the clear.
- R7: A command (nonzero `cmd_op`) issued while busy is refused and sets `flags` bit 1. The running operation continues with its own timing and target.
- R8: A program to a halfword that does not read 16'hFFFF is refused and sets `flags` bit 2. `busy` stays low and the array is unchanged.
- R9: A command is refused with `flags` bit 3 set when any of these holds: `lock` is high; a program or page erase targets an address at or beyond the array end; or a program or page erase targets an information page while `info_wen` is low. The checks apply in this priority: busy first, then these protection checks, then the blank check of R8.
- R10: `irq` equals flag bit 0 AND `eop_ie`. `wake` equals `irq` AND `if_clk_en`.
- R11: `cmd_op` encoding: 0 none (ignored, no flag), 1 program, 2 page erase, 3 mass erase.
- R12: Synchronous reset sets every halfword to 16'hFFFF and clears `busy` and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe from the fixed reference clock |
| lock | input | 1 | Blocks all commands while high |
| info_wen | input | 1 | Permits program and page erase on information pages |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| cmd_addr | input | 6 | Halfword address of the command |
| cmd_wdata | input | 16 | Program data |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| eop_ie | input | 1 | End-of-operation interrupt enable |
| if_clk_en | input | 1 | Interface clock enable, gates the wake request |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Halfword at the read address |
| busy | output | 1 | Operation in progress |
| flags | output | 4 | {protection error, program error, busy error, end of operation} |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request |

## Verification
A wrong remaining-tick count or a lost operation register shows at the end of that same operation. Either `busy` falls on the wrong tick, or `rd_data` shows a wrong word at the next read of the target page. A cycle-level reference model compares `busy`, all four flags, `irq`, `wake` and a randomly addressed `rd_data` after every edge, so a divergence is reported within one cycle of the edge that caused it. An erase that reaches the wrong rows stays latent until those rows are read. Random read addresses and directed reads of the neighbouring page and of the information area bound that delay.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_PAGE = 2'd2,
        OP_MASS = 2'd3
    } fop_e;

    typedef enum logic [2:0] {
        V_IGNORE,
        V_ACCEPT,
        V_BUSY,
        V_PROT,
        V_PGERR
    } verdict_e;

    // bit 0 is eop, bit 3 is prot_err
    typedef struct packed {
        logic prot_err;
        logic pg_err;
        logic busy_err;
        logic eop;
    } fflags_t;

    localparam logic [15:0] ERASED_HW = 16'hFFFF;

    function automatic logic is_blank(input logic [15:0] w);
        return w == ERASED_HW;
    endfunction

    function automatic int op_ticks(input fop_e op, input int t_prog,
                                    input int t_page, input int t_mass);
        case (op)
            OP_PROG: return t_prog;
            OP_PAGE: return t_page;
            OP_MASS: return t_mass;
            default: return 1;
        endcase
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fseq_cmd_check.sv
module fseq_cmd_check
    import flash_seq_pkg::*;
#(
    parameter int AW       = 6,
    parameter int MAIN_HW  = 32,
    parameter int TOTAL_HW = 40
) (
    input  logic          cmd_valid,
    input  fop_e          op,
    input  logic [AW-1:0] addr,
    input  logic          busy,
    input  logic          lock,
    input  logic          info_wen,
    input  logic [15:0]   cur_word,
    output verdict_e      verdict
);

    logic beyond_end;
    logic in_info;

    assign beyond_end = int'(addr) >= TOTAL_HW;
    assign in_info    = int'(addr) >= MAIN_HW;

    always_comb begin
        verdict = V_ACCEPT;
        if (!cmd_valid || op == OP_NONE) begin
            verdict = V_IGNORE;
        end else if (busy) begin
            verdict = V_BUSY;
        end else if (lock) begin
            verdict = V_PROT;
        end else if (op != OP_MASS && beyond_end) begin
            verdict = V_PROT;
        end else if (op != OP_MASS && in_info && !info_wen) begin
            verdict = V_PROT;
        end else if (op == OP_PROG && !is_blank(cur_word)) begin
            verdict = V_PGERR;
        end
    end

endmodule

// File: rtl/fseq_timer.sv
module fseq_timer
    import flash_seq_pkg::*;
#(
    parameter int CW         = 4,
    parameter int PROG_TICKS = 3,
    parameter int PAGE_TICKS = 6,
    parameter int MASS_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  fop_e start_op,
    input  logic tick,
    output logic busy,
    output logic done
);

    logic [CW-1:0] rem_q;
    logic          busy_q;

    assign busy = busy_q;
    assign done = busy_q && tick && (rem_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            rem_q  <= CW'(op_ticks(start_op, PROG_TICKS, PAGE_TICKS, MASS_TICKS));
        end else if (done) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
        end else if (busy_q && tick) begin
            rem_q  <= rem_q - CW'(1);
        end
    end

    // R4
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick && !start) |=> (busy_q && $stable(rem_q)));

    // R5
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy_q);

endmodule

// File: rtl/fseq_array.sv
module fseq_array
    import flash_seq_pkg::*;
#(
    parameter int AW       = 6,
    parameter int PAGE_HW  = 8,
    parameter int MAIN_HW  = 32,
    parameter int TOTAL_HW = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          apply,
    input  fop_e          op,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data,
    input  logic [AW-1:0] chk_addr,
    output logic [15:0]   chk_data
);

    localparam int PG_SH = $clog2(PAGE_HW);

    logic [15:0] mem [TOTAL_HW];

    assign rd_data  = (int'(rd_addr)  < TOTAL_HW) ? mem[rd_addr]  : ERASED_HW;
    assign chk_data = (int'(chk_addr) < TOTAL_HW) ? mem[chk_addr] : ERASED_HW;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TOTAL_HW; i++) begin
                mem[i] <= ERASED_HW;
            end
        end else if (apply) begin
            for (int i = 0; i < TOTAL_HW; i++) begin
                case (op)
                    OP_PROG: if (AW'(i) == addr) mem[i] <= wdata;
                    OP_PAGE: if ((AW'(i) >> PG_SH) == (addr >> PG_SH)) mem[i] <= ERASED_HW;
                    OP_MASS: if (i < MAIN_HW) mem[i] <= ERASED_HW;
                    default: ;
                endcase
            end
        end
    end

    for (genvar k = MAIN_HW; k < TOTAL_HW; k++) begin : g_info_guard
        // R3
        mass_info_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (apply && op == OP_MASS) |=> (mem[k] == $past(mem[k])));
    end

endmodule

// File: rtl/fseq_flags.sv
module fseq_flags
    import flash_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fflags_t    set,
    input  logic [3:0] clr,
    input  logic       ie,
    input  logic       clk_en,
    output fflags_t    flags,
    output logic       irq,
    output logic       wake
);

    logic [3:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr) | set;
        end
    end

    assign flags = fflags_t'(flag_q);
    assign irq   = flags.eop & ie;
    assign wake  = irq & clk_en;

    // R6
    eop_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags.eop && !clr[0]) |=> flags.eop);

    // R6
    eop_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set.eop |=> flags.eop);

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int MAIN_PAGES = 4,
    parameter int INFO_PAGES = 1,
    parameter int PAGE_HW    = 8,
    parameter int PROG_TICKS = 3,
    parameter int PAGE_TICKS = 6,
    parameter int MASS_TICKS = 10,
    localparam int MAIN_HW   = MAIN_PAGES * PAGE_HW,
    localparam int TOTAL_HW  = (MAIN_PAGES + INFO_PAGES) * PAGE_HW,
    localparam int AW        = $clog2(TOTAL_HW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          lock,
    input  logic          info_wen,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [15:0]   cmd_wdata,
    input  logic [3:0]    flag_clr,
    input  logic          eop_ie,
    input  logic          if_clk_en,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data,
    output logic          busy,
    output logic [3:0]    flags,
    output logic          irq,
    output logic          wake
);

    localparam int MAXT = max3(PROG_TICKS, PAGE_TICKS, MASS_TICKS);
    localparam int CW   = $clog2(MAXT + 1);

    fop_e          req_op;
    verdict_e      verdict;
    logic          accept;
    logic          done;
    logic [15:0]   cur_word;
    fflags_t       flag_set;
    fflags_t       flg;

    fop_e          cur_op_q;
    logic [AW-1:0] cur_addr_q;
    logic [15:0]   cur_data_q;

    assign req_op = fop_e'(cmd_op);
    assign accept = (verdict == V_ACCEPT);

    fseq_cmd_check #(
        .AW(AW), .MAIN_HW(MAIN_HW), .TOTAL_HW(TOTAL_HW)
    ) u_check (
        .cmd_valid(cmd_valid),
        .op(req_op),
        .addr(cmd_addr),
        .busy(busy),
        .lock(lock),
        .info_wen(info_wen),
        .cur_word(cur_word),
        .verdict(verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_op_q   <= OP_NONE;
            cur_addr_q <= '0;
            cur_data_q <= ERASED_HW;
        end else if (accept) begin
            cur_op_q   <= req_op;
            cur_addr_q <= cmd_addr;
            cur_data_q <= cmd_wdata;
        end
    end

    fseq_timer #(
        .CW(CW), .PROG_TICKS(PROG_TICKS), .PAGE_TICKS(PAGE_TICKS), .MASS_TICKS(MASS_TICKS)
    ) u_timer (
        .clk(clk),
        .rst(rst),
        .start(accept),
        .start_op(req_op),
        .tick(tick),
        .busy(busy),
        .done(done)
    );

    fseq_array #(
        .AW(AW), .PAGE_HW(PAGE_HW), .MAIN_HW(MAIN_HW), .TOTAL_HW(TOTAL_HW)
    ) u_array (
        .clk(clk),
        .rst(rst),
        .apply(done),
        .op(cur_op_q),
        .addr(cur_addr_q),
        .wdata(cur_data_q),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .chk_addr(cmd_addr),
        .chk_data(cur_word)
    );

    always_comb begin
        flag_set          = '0;
        flag_set.eop      = done;
        flag_set.busy_err = (verdict == V_BUSY);
        flag_set.pg_err   = (verdict == V_PGERR);
        flag_set.prot_err = (verdict == V_PROT);
    end

    fseq_flags u_flags (
        .clk(clk),
        .rst(rst),
        .set(flag_set),
        .clr(flag_clr),
        .ie(eop_ie),
        .clk_en(if_clk_en),
        .flags(flg),
        .irq(irq),
        .wake(wake)
    );

    assign flags = flg;

    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(accept));

    // R5
    busy_fall_eop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> flg.eop);

    // R7
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid && cmd_op != 2'd0) |=> (flg.busy_err && $stable(cur_op_q) && $stable(cur_addr_q)));

    // R8
    pg_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (verdict == V_PGERR) |=> (!busy && flg.pg_err));

    // R9
    prot_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (verdict == V_PROT) |=> (!busy && flg.prot_err));

endmodule

// File: tb/flash_seq_test.sv
module flash_seq_test;

    localparam int MAIN_PAGES = 4;
    localparam int INFO_PAGES = 1;
    localparam int PAGE_HW    = 8;
    localparam int PROG_T     = 3;
    localparam int PAGE_T     = 6;
    localparam int MASS_T     = 10;
    localparam int MAIN_HW    = MAIN_PAGES * PAGE_HW;
    localparam int TOTAL_HW   = (MAIN_PAGES + INFO_PAGES) * PAGE_HW;
    localparam int AW         = $clog2(TOTAL_HW);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          lock = 1'b0;
    logic          info_wen = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [15:0]   cmd_wdata = '0;
    logic [3:0]    flag_clr = '0;
    logic          eop_ie = 1'b0;
    logic          if_clk_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          busy;
    logic [3:0]    flags;
    logic          irq;
    logic          wake;

    flash_seq #(
        .MAIN_PAGES(MAIN_PAGES), .INFO_PAGES(INFO_PAGES), .PAGE_HW(PAGE_HW),
        .PROG_TICKS(PROG_T), .PAGE_TICKS(PAGE_T), .MASS_TICKS(MASS_T)
    ) uut (
        .clk(clk), .rst(rst), .tick(tick), .lock(lock), .info_wen(info_wen),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .flag_clr(flag_clr), .eop_ie(eop_ie),
        .if_clk_en(if_clk_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .flags(flags), .irq(irq), .wake(wake)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [15:0] m_mem [TOTAL_HW];
    logic        m_busy;
    int          m_rem;
    logic [1:0]  m_op;
    int          m_addr;
    logic [15:0] m_data;
    logic [3:0]  m_flags;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ticks_of(input logic [1:0] op);
        return (op == 2'd1) ? PROG_T : (op == 2'd2) ? PAGE_T : MASS_T;
    endfunction

    function automatic logic [15:0] m_read(input int a);
        return (a < TOTAL_HW) ? m_mem[a] : 16'hFFFF;
    endfunction

    // 0 ignore, 1 accept, 2 busy, 3 protection, 4 not blank
    function automatic int verdict_of();
        if (!cmd_valid || cmd_op == 2'd0) return 0;
        if (m_busy) return 2;
        if (lock) return 3;
        if (cmd_op != 2'd3 && int'(cmd_addr) >= TOTAL_HW) return 3;
        if (cmd_op != 2'd3 && int'(cmd_addr) >= MAIN_HW && !info_wen) return 3;
        if (cmd_op == 2'd1 && m_read(int'(cmd_addr)) != 16'hFFFF) return 4;
        return 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < TOTAL_HW; i++) m_mem[i] = 16'hFFFF;
        m_busy = 0; m_rem = 0; m_flags = 0; m_op = 0; m_addr = 0; m_data = 0;
    endtask

    task automatic model_edge();
        logic       done;
        logic [3:0] setv;
        int         v;
        done = m_busy && tick && (m_rem == 1);
        v = verdict_of();
        setv = 4'b0;
        setv[0] = done;
        if (v == 2) setv[1] = 1'b1;
        if (v == 4) setv[2] = 1'b1;
        if (v == 3) setv[3] = 1'b1;
        m_flags = (m_flags & ~flag_clr) | setv;
        if (done) begin
            for (int i = 0; i < TOTAL_HW; i++) begin
                if (m_op == 2'd1 && i == m_addr) m_mem[i] = m_data;
                if (m_op == 2'd2 && (i / PAGE_HW) == (m_addr / PAGE_HW)) m_mem[i] = 16'hFFFF;
                if (m_op == 2'd3 && i < MAIN_HW) m_mem[i] = 16'hFFFF;
            end
            m_busy = 0;
        end else if (v == 1) begin
            m_busy = 1; m_rem = ticks_of(cmd_op);
            m_op = cmd_op; m_addr = int'(cmd_addr); m_data = cmd_wdata;
        end else if (m_busy && tick) begin
            m_rem--;
        end
    endtask

    task automatic compare_all();
        check("R5 busy", busy, m_busy);
        check("R6 eop flag", flags[0], m_flags[0]);
        check("R7 busy_err flag", flags[1], m_flags[1]);
        check("R8 pg_err flag", flags[2], m_flags[2]);
        check("R9 prot_err flag", flags[3], m_flags[3]);
        check("R10 irq", irq, m_flags[0] & eop_ie);
        check("R10 wake", wake, m_flags[0] & eop_ie & if_clk_en);
        check("R1 rd_data", rd_data, m_read(int'(rd_addr)));
    endtask

    task automatic cycle();
        @(posedge clk);
        if (rst) model_reset(); else model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic issue(input logic [1:0] op, input int a, input logic [15:0] d);
        cmd_valid = 1; cmd_op = op; cmd_addr = AW'(a); cmd_wdata = d; tick = 0;
        cycle();
        cmd_valid = 0; cmd_op = 0;
    endtask

    task automatic wait_idle(input int period, output int nt);
        int k;
        k = 0; nt = 0;
        while (busy && k < 500) begin
            tick = (k % period == 0);
            if (tick) nt++;
            cycle();
            k++;
        end
        tick = 0;
    endtask

    task automatic clear_flags();
        flag_clr = 4'hF; cycle(); flag_clr = 4'h0;
    endtask

    task automatic read_chk(input string tag, input int a, input logic [15:0] exp);
        rd_addr = AW'(a); #1;
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R5 actual=busy_hang expected=idle");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int nt;
        void'($urandom(32'd20240611));
        @(negedge clk);
        cycle(); cycle();
        rst = 0;
        cycle();
        // R12 reset state
        check("R12 busy", busy, 0);
        check("R12 flags", flags, 0);
        read_chk("R12 word0", 0, 16'hFFFF);
        read_chk("R12 last word", TOTAL_HW - 1, 16'hFFFF);

        // R1, R4 program with a tick every cycle
        issue(2'd1, 5, 16'h1234);
        check("R5 busy after accept", busy, 1);
        wait_idle(1, nt);
        check("R4 program ticks", nt, PROG_T);
        check("R5 eop at busy fall", flags[0], 1);
        read_chk("R1 programmed word", 5, 16'h1234);
        read_chk("R1 neighbour word", 6, 16'hFFFF);

        // R8 program over non-blank
        issue(2'd1, 5, 16'h0000);
        check("R8 pg_err", flags[2], 1);
        check("R8 no busy", busy, 0);
        read_chk("R8 word kept", 5, 16'h1234);
        clear_flags();
        check("R6 cleared", flags, 0);

        // R3 mass erase keeps info area, ticks gapped
        info_wen = 1;
        issue(2'd1, MAIN_HW + 1, 16'hA5A5);
        wait_idle(2, nt);
        check("R4 gapped ticks", nt, PROG_T);
        info_wen = 0;
        issue(2'd1, 9, 16'h0F0F);
        wait_idle(3, nt);
        issue(2'd3, 0, 16'h0);
        wait_idle(1, nt);
        check("R4 mass ticks", nt, MASS_T);
        read_chk("R3 info kept", MAIN_HW + 1, 16'hA5A5);
        read_chk("R3 main erased", 9, 16'hFFFF);
        read_chk("R3 main erased b", 5, 16'hFFFF);
        clear_flags();

        // R9 protection
        issue(2'd1, MAIN_HW + 2, 16'h0001);
        check("R9 info without enable", flags[3], 1);
        check("R9 no busy", busy, 0);
        clear_flags();
        issue(2'd2, TOTAL_HW + 3, 16'h0);
        check("R9 beyond end", flags[3], 1);
        clear_flags();
        lock = 1;
        issue(2'd3, 0, 16'h0);
        check("R9 locked", flags[3], 1);
        check("R9 locked no busy", busy, 0);
        lock = 0;
        clear_flags();

        // R2 page erase
        issue(2'd1, 3, 16'h1111); wait_idle(1, nt);
        issue(2'd1, 12, 16'h7777); wait_idle(1, nt);
        issue(2'd2, 8, 16'h0);
        wait_idle(1, nt);
        check("R4 page ticks", nt, PAGE_T);
        read_chk("R2 page word erased", 12, 16'hFFFF);
        read_chk("R2 other page kept", 3, 16'h1111);
        info_wen = 1;
        issue(2'd2, MAIN_HW + 5, 16'h0); wait_idle(1, nt);
        read_chk("R2 info page erased", MAIN_HW + 1, 16'hFFFF);
        info_wen = 0;
        clear_flags();

        // R7 command while busy
        issue(2'd2, 0, 16'h0);
        issue(2'd1, 20, 16'h4242);
        check("R7 busy_err", flags[1], 1);
        check("R7 still busy", busy, 1);
        wait_idle(1, nt);
        check("R7 original timing", nt, PAGE_T);
        read_chk("R7 rejected program absent", 20, 16'hFFFF);
        read_chk("R7 original erase done", 3, 16'hFFFF);

        // R10 interrupt and wake gating
        eop_ie = 1; if_clk_en = 0; #1;
        check("R10 irq pending", irq, 1);
        check("R10 no wake", wake, 0);
        if_clk_en = 1; #1;
        check("R10 wake", wake, 1);
        flag_clr = 4'h1; cycle(); flag_clr = 0;
        check("R10 irq cleared", irq, 0);
        clear_flags();

        // R11 code zero ignored
        cmd_valid = 1; cmd_op = 2'd0; cmd_addr = 6'd1; cycle(); cmd_valid = 0;
        check("R11 no busy", busy, 0);
        check("R11 no flag", flags, 0);

        // R6 set wins over clear
        issue(2'd1, 30, 16'h00FF);
        flag_clr = 4'h1; tick = 1; cycle(); cycle(); cycle(); tick = 0; flag_clr = 0;
        check("R6 set beats clear", flags[0], 1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            cmd_valid = ($urandom % 4 == 0);
            cmd_op    = 2'($urandom % 4);
            cmd_addr  = AW'($urandom_range(0, TOTAL_HW + 7));
            cmd_wdata = ($urandom % 3 == 0) ? 16'hFFFF : 16'($urandom);
            lock      = ($urandom % 10 == 0);
            info_wen  = 1'($urandom % 2);
            tick      = 1'($urandom % 2);
            flag_clr  = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'h0;
            eop_ie    = 1'($urandom % 2);
            if_clk_en = 1'($urandom % 2);
            rd_addr   = AW'($urandom_range(0, TOTAL_HW + 7));
            cycle();
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule